// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a slave-only two-wire control port that owns a bank of three 8-bit configuration registers for the clock-control logic. A system clock much faster than the bus samples SCL and SDA through two-flop synchronizers. The block detects start and stop conditions from the synchronized lines. It answers one fixed device address. It drives SDA only by pulling it low.

A write transaction carries the write address, a command byte whose contents are ignored, and a byte count. Data bytes then fill register 0, register 1 and register 2 in that order. A read transaction returns the register count first and then the three registers. Some bit positions are not stored. They show live input pins, or the AND of a stored bit and a pin. The readback view of all three registers is exported to the neighbouring clock logic.

Top module: `smb_cfg_slave`

## Requirements
- R1: The block acknowledges only address byte 0xD2 (write) and 0xD3 (read). Any other address byte gets no ACK, and the block stays silent until the next start condition.
- R2: In a write, the two bytes after the address (command byte, then byte count) are both acknowledged, and the value of the command byte has no effect on the resulting registers.
- R3: Data bytes are acknowledged and stored into register 0, 1, 2 in arrival order. A write with fewer bytes changes only the registers it reached. Bytes after the third are acknowledged and discarded.
- R4: Reset sets the stored bits as follows: register 0 bits 7:5 = 0, register 0 bit 3 = 1, register 1 bits 6:3 = 0, register 1 bits 2:0 = 1, register 2 = 0x00. Stored bits change only through data bytes of a write.
- R5: Register 0 bits 2:0 always read the three frequency-select pins (pin bit n at bit n), and register 0 bit 4 always reads the CPU-stop pin.
- R6: Register 0 bit 3 reads the AND of its stored bit and the PCI-stop pin.
- R7: Register 1 bit 7 always reads the multiplier-select pin.
- R8: Data written to read-only positions (register 0 bits 4 and 2:0, register 1 bit 7) is acknowledged and has no effect.
- R9: A read returns 0x03 and then registers 0, 1, 2, each MSB first. Further bytes read 0x00. A master NACK releases the bus.
- R10: SDA is never driven high. The pull-down changes only while SCL is low, and an ACK holds SDA low for the ninth clock.
- R11: A stop condition at any point returns the block to idle. A repeated start begins a new address phase, and the interrupted transfer leaves the registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| fsel_i | input | 3 | Frequency-select pins |
| cpu_stop_i | input | 1 | CPU-stop pin |
| pci_stop_i | input | 1 | PCI-stop pin |
| mult_sel_i | input | 1 | Multiplier-select pin |
| cfg_reg0_o | output | 8 | Readback view of register 0 |
| cfg_reg1_o | output | 8 | Readback view of register 1 |
| cfg_reg2_o | output | 8 | Readback view of register 2 |

## Verification
The bench writes the bank with all-ones, all-zeros and mixed data. Comparing these against a model that masks read-only positions shows whether stored bits and pin-reflected bits are kept apart. It repeats writes with different command bytes, and with one, three and five data bytes, to separate command-independence, fill order and discard of extras. It also runs foreign addresses, a repeated start into a read, and a stop in mid-byte, which show whether the address phase and abort handling are correct. While the bus is idle, every clock compares the exported registers with the model as the pins toggle. A monitor flags any SDA pull-down edge that falls while SCL is high.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  localparam int NUM_REGS = 3;
  localparam int FSEL_W   = 3;
  localparam int HDR_BYTES = 3;  // address, command, count
  localparam int BIT_CPU  = 4;
  localparam int BIT_PCI  = 3;
  localparam int BIT_MULT = 7;

  // writable bits of each register, and their power-on values
  localparam logic [7:0] WMASK   [NUM_REGS] = '{8'hE8, 8'h7F, 8'hFF};
  localparam logic [7:0] RST_VAL [NUM_REGS] = '{8'h08, 8'h07, 8'h00};

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK_WAIT, ST_ACK, ST_TX, ST_TX_ACK
  } bus_st_e;

  typedef struct packed {
    logic scl;
    logic sda;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_ev_t;
endpackage

// File: rtl/smb_bus_sync.sv
module smb_bus_sync import smb_cfg_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s = scl_ff[SYNC_STAGES-1];
  assign sda_s = sda_ff[SYNC_STAGES-1];

  always_comb begin
    ev_o.scl      = scl_s;
    ev_o.sda      = sda_s;
    ev_o.scl_rise = scl_s & ~scl_d;
    ev_o.scl_fall = ~scl_s & scl_d;
    ev_o.start    = scl_s & scl_d & sda_d & ~sda_s;
    ev_o.stop     = scl_s & scl_d & ~sda_d & sda_s;
  end
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank import smb_cfg_pkg::*; #(
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [IDX_W-1:0]             wr_idx_i,
  input  logic [7:0]                   wr_data_i,
  input  logic [FSEL_W-1:0]            fsel_i,
  input  logic                         cpu_stop_i,
  input  logic                         pci_stop_i,
  input  logic                         mult_sel_i,
  output logic [NUM_REGS-1:0][7:0]     rd_o
);
  logic [7:0] st_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[g] <= RST_VAL[g];
      else if (wr_en_i && wr_idx_i == IDX_W'(g))
        st_q[g] <= (st_q[g] & ~WMASK[g]) | (wr_data_i & WMASK[g]);
    end

    AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_idx_i == IDX_W'(g)) |=> $stable(st_q[g])); // R4
  end

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) rd_o[i] = st_q[i] & WMASK[i];
    rd_o[0][FSEL_W-1:0] = fsel_i;
    rd_o[0][BIT_CPU]    = cpu_stop_i;
    rd_o[0][BIT_PCI]    = st_q[0][BIT_PCI] & pci_stop_i;
    rd_o[1][BIT_MULT]   = mult_sel_i;
  end

  AST_WR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (int'(wr_idx_i) < NUM_REGS)); // R3
endmodule

// File: rtl/smb_byte_engine.sv
module smb_byte_engine import smb_cfg_pkg::*; #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  localparam int IDX_W = $clog2(NUM_REGS),
  localparam int CNT_W = $clog2(NUM_REGS + HDR_BYTES + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  bus_ev_t                  ev_i,
  input  logic [NUM_REGS-1:0][7:0] rd_i,
  output logic                     sda_oe_o,
  output logic                     wr_en_o,
  output logic [IDX_W-1:0]         wr_idx_o,
  output logic [7:0]               wr_data_o
);
  bus_st_e          st;
  logic [2:0]       bit_cnt;
  logic [7:0]       shreg, full, addr_q;
  logic [CNT_W-1:0] byte_idx, data_pos;
  logic             mack;

  // item 0 is the count byte, then the registers, then zeros
  function automatic logic [7:0] tx_pick(input logic [CNT_W-1:0] item,
                                         input logic [NUM_REGS-1:0][7:0] rd);
    logic [7:0] r;
    r = (item == '0) ? 8'(NUM_REGS) : 8'h00;
    for (int k = 0; k < NUM_REGS; k++)
      if (int'(item) == k + 1) r = rd[k];
    return r;
  endfunction

  assign full     = {shreg[6:0], ev_i.sda};
  assign data_pos = byte_idx - CNT_W'(HDR_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      addr_q    <= '0;
      byte_idx  <= '0;
      mack      <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (ev_i.start) begin
        st       <= ST_RX;
        bit_cnt  <= '0;
        byte_idx <= '0;
      end else if (ev_i.stop) begin
        st <= ST_IDLE;
      end else begin
        unique case (st)
          ST_RX: if (ev_i.scl_rise) begin
            shreg   <= full;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              if (byte_idx == '0) begin
                addr_q <= full;
                st     <= (full[7:1] == DEV_ADDR) ? ST_ACK_WAIT : ST_IDLE;
              end else begin
                st <= ST_ACK_WAIT;
                if (byte_idx >= CNT_W'(HDR_BYTES) && data_pos < CNT_W'(NUM_REGS)) begin
                  wr_en_o   <= 1'b1;
                  wr_idx_o  <= IDX_W'(data_pos);
                  wr_data_o <= full;
                end
              end
              if (byte_idx != '1) byte_idx <= byte_idx + 1'b1;
            end
          end
          ST_ACK_WAIT: if (ev_i.scl_fall) st <= ST_ACK;
          ST_ACK: if (ev_i.scl_fall) begin
            bit_cnt <= '0;
            if (addr_q[0]) begin
              shreg <= tx_pick(byte_idx - 1'b1, rd_i);
              st    <= ST_TX;
              if (byte_idx != '1) byte_idx <= byte_idx + 1'b1;
            end else begin
              st <= ST_RX;
            end
          end
          ST_TX: if (ev_i.scl_fall) begin
            if (bit_cnt == 3'd7) st <= ST_TX_ACK;
            else begin
              shreg   <= {shreg[6:0], 1'b0};
              bit_cnt <= bit_cnt + 3'd1;
            end
          end
          ST_TX_ACK: begin
            if (ev_i.scl_rise) mack <= ~ev_i.sda;
            if (ev_i.scl_fall) begin
              if (mack) begin
                shreg   <= tx_pick(byte_idx - 1'b1, rd_i);
                bit_cnt <= '0;
                st      <= ST_TX;
                if (byte_idx != '1) byte_idx <= byte_idx + 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // open drain: only a pull-down request leaves this block
  assign sda_oe_o = (st == ST_ACK) || (st == ST_TX && !shreg[7]);

  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !ev_i.scl); // R10

  AST_ADDR_ACK_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_ACK && byte_idx == CNT_W'(1)) |-> (addr_q[7:1] == DEV_ADDR)); // R1

  AST_TX_ONLY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_TX) |-> addr_q[0]); // R9
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave import smb_cfg_pkg::*; #(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [FSEL_W-1:0] fsel_i,
  input  logic              cpu_stop_i,
  input  logic              pci_stop_i,
  input  logic              mult_sel_i,
  output logic [7:0]        cfg_reg0_o,
  output logic [7:0]        cfg_reg1_o,
  output logic [7:0]        cfg_reg2_o
);
  localparam int IDX_W = $clog2(NUM_REGS);

  bus_ev_t                  ev;
  logic [NUM_REGS-1:0][7:0] rd;
  logic                     wr_en;
  logic [IDX_W-1:0]         wr_idx;
  logic [7:0]               wr_data;

  smb_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i, .ev_o(ev)
  );

  smb_byte_engine #(.DEV_ADDR(DEV_ADDR)) i_engine (
    .clk_i, .rst_ni, .ev_i(ev), .rd_i(rd), .sda_oe_o,
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  smb_reg_bank i_bank (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .fsel_i, .cpu_stop_i, .pci_stop_i, .mult_sel_i, .rd_o(rd)
  );

  assign cfg_reg0_o = rd[0];
  assign cfg_reg1_o = rd[1];
  assign cfg_reg2_o = rd[2];
endmodule

// File: tb/test_smb_cfg_slave.sv
module test_smb_cfg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 20;  // system clocks per quarter-ish bus phase

  logic clk_i = 0, rst_ni = 0;
  logic m_scl = 1, m_sda_low = 0;
  logic sda_oe;
  logic sda_line;
  logic [2:0] fsel = 3'b101;
  logic cpu = 1, pci = 1, mult = 0;
  logic [7:0] c0, c1, c2;

  int tests = 0, fails = 0, r10_viol = 0;
  bit chk_en = 0, done = 0;
  logic [7:0] m [3];  // model of stored bits
  logic prev_oe = 0;

  assign sda_line = !(m_sda_low || sda_oe);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  smb_cfg_slave i_smb_cfg_slave (
    .clk_i, .rst_ni, .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .fsel_i(fsel), .cpu_stop_i(cpu), .pci_stop_i(pci), .mult_sel_i(mult),
    .cfg_reg0_o(c0), .cfg_reg1_o(c1), .cfg_reg2_o(c2)
  );

  function automatic logic [7:0] e0();
    return {m[0][7:5], cpu, m[0][3] & pci, fsel};
  endfunction
  function automatic logic [7:0] e1();
    return {mult, m[1][6:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model while the bus is idle (R4..R7)
  always @(negedge clk_i) begin
    if (rst_ni && prev_oe !== sda_oe && m_scl) r10_viol++;
    prev_oe = sda_oe;
    if (chk_en) begin
      check(c0 === e0(), "R5_R6_idle_reg0", c0, e0());
      check(c1 === e1(), "R7_idle_reg1", c1, e1());
      check(c2 === m[2], "R4_idle_reg2", c2, m[2]);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic bus_start();
    m_sda_low = 0; tick(Q); m_scl = 1; tick(Q); m_sda_low = 1; tick(Q); m_scl = 0; tick(Q);
  endtask
  task automatic bus_stop();
    m_sda_low = 1; tick(Q); m_scl = 1; tick(Q); m_sda_low = 0; tick(Q);
  endtask
  task automatic put_bit(input logic b);
    m_sda_low = !b; tick(Q); m_scl = 1; tick(Q); m_scl = 0; tick(2);
  endtask
  task automatic get_bit(output logic b);
    m_sda_low = 0; tick(Q); m_scl = 1; tick(Q/2); b = sda_line; tick(Q/2); m_scl = 0; tick(2);
  endtask
  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = !b;
  endtask
  task automatic recv_byte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(!ack);
  endtask

  task automatic model_wr(input int idx, input logic [7:0] d);
    logic [7:0] wm;
    wm = (idx == 0) ? 8'hE8 : (idx == 1) ? 8'h7F : 8'hFF;
    m[idx] = (m[idx] & ~wm) | (d & wm);
  endtask

  task automatic wr_txn(input logic [7:0] cmd, input int n, input logic [7:0] d [5]);
    logic a;
    chk_en = 0;
    bus_start();
    send_byte(8'hD2, a); check(a, "R1_write_addr_ack", {7'd0, a}, 8'd1);
    send_byte(cmd, a);   check(a, "R2_cmd_ack", {7'd0, a}, 8'd1);
    send_byte(8'd3, a);  check(a, "R2_count_ack", {7'd0, a}, 8'd1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], a); check(a, "R3_data_ack", {7'd0, a}, 8'd1);
    end
    bus_stop();
    for (int i = 0; i < n && i < 3; i++) model_wr(i, d[i]);
    tick(4);
    chk_en = 1;
  endtask

  task automatic rd_txn(input int n, input bit with_start);
    logic a;
    logic [7:0] v, ex;
    chk_en = 0;
    if (with_start) bus_start();
    send_byte(8'hD3, a); check(a, "R1_read_addr_ack", {7'd0, a}, 8'd1);
    for (int i = 0; i < n; i++) begin
      ex = (i == 0) ? 8'h03 : (i == 1) ? e0() : (i == 2) ? e1() : (i == 3) ? m[2] : 8'h00;
      recv_byte(v, i != n - 1);
      check(v === ex, "R9_read_byte", v, ex);
    end
    check(sda_line === 1'b1, "R9_release_after_nack", {7'd0, sda_line}, 8'd1);
    bus_stop();
    tick(4);
    chk_en = 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic a;
    m[0] = 8'h08; m[1] = 8'h07; m[2] = 8'h00;
    tick(5); rst_ni = 1; tick(5);
    // R4 reset defaults with pins fsel=101 cpu=1 pci=1 mult=0
    check(c0 === 8'h1D, "R4_reset_reg0", c0, 8'h1D);
    check(c1 === 8'h07, "R4_reset_reg1", c1, 8'h07);
    check(c2 === 8'h00, "R4_reset_reg2", c2, 8'h00);
    check(sda_oe === 1'b0, "R10_reset_release", {7'd0, sda_oe}, 8'd0);
    chk_en = 1;

    // R1 foreign addresses get no ACK and change nothing
    chk_en = 0;
    bus_start(); send_byte(8'hA4, a); check(!a, "R1_foreign_nack", {7'd0, a}, 8'd0);
    send_byte(8'hFF, a); check(!a, "R1_silent_after_foreign", {7'd0, a}, 8'd0);
    bus_stop();
    bus_start(); send_byte(8'hD0, a); check(!a, "R1_near_addr_nack", {7'd0, a}, 8'd0);
    bus_stop(); tick(4); chk_en = 1;

    // R3/R8 all-ones, zeros, mixed; read-only positions keep pin values
    wr_txn(8'h00, 3, '{8'hFF, 8'h00, 8'hA5, 8'h00, 8'h00});
    check(c0 === 8'hFD, "R8_ro_bits_reg0", c0, 8'hFD);
    check(c1 === 8'h00, "R8_ro_bit_reg1", c1, 8'h00);
    rd_txn(4, 1);

    // R2 different command, R3 extras discarded
    wr_txn(8'h5A, 5, '{8'h00, 8'hFF, 8'h3C, 8'h11, 8'h22});
    check(c2 === 8'h3C, "R3_extras_discarded", c2, 8'h3C);
    check(c1 === 8'h7F, "R2_cmd_ignored", c1, 8'h7F);

    // R5/R6/R7 live pins
    tick(3); fsel = 3'b010; cpu = 0; mult = 1; pci = 0; tick(3);
    check(c0 === 8'h02, "R5_live_pins_reg0", c0, 8'h02);
    check(c1 === 8'hFF, "R7_mult_pin", c1, 8'hFF);

    // R3 partial write, R6 AND function
    wr_txn(8'hC3, 1, '{8'h08, 8'h00, 8'h00, 8'h00, 8'h00});
    check(c0 === 8'h02, "R6_and_pin_low", c0, 8'h02);
    check(c1 === 8'hFF && c2 === 8'h3C, "R3_partial_write", c2, 8'h3C);
    pci = 1; tick(3);
    check(c0 === 8'h0A, "R6_and_pin_high", c0, 8'h0A);

    // R11 repeated start from a write into a read
    chk_en = 0;
    bus_start(); send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h03, a);
    check(a, "R11_count_ack", {7'd0, a}, 8'd1);
    bus_start();
    rd_txn(6, 0);

    // R11 stop in mid-byte, then a normal write still works
    chk_en = 0;
    bus_start(); send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h03, a);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop(); tick(4);
    check(c0 === e0(), "R11_abort_no_change", c0, e0());
    chk_en = 1;
    wr_txn(8'h00, 3, '{8'hA0, 8'h55, 8'h81, 8'h00, 8'h00});
    rd_txn(4, 1);

    check(r10_viol == 0, "R10_oe_edge_scl_low", 8'(r10_viol), 8'd0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule